// File: doc/BRIEF.md
# Four-Channel External Interrupt Controller

This block watches four asynchronous external interrupt inputs and keeps one sticky flag per channel. Each input goes through a two-flop synchronizer. A detector then decides, under that channel's own trigger-mode and polarity bits, whether the input shows an interrupt condition. A channel can trigger on a rising edge, a falling edge, an active-high level or an active-low level. Each channel drives its own interrupt request line, and that line follows the channel's flag.

Software reaches the block through a simple synchronous register port: a write strobe, a read strobe, a small address and a 32-bit data bus. Three registers hold the flags, the trigger modes and the polarities. Software clears a flag by writing a one to its bit. When hardware sets a flag in the same cycle that software clears it, the hardware set takes priority, so no event is lost.

Top module: `xirq_ctrl`

## Requirements
- R1: There are four channels. Bit n of the flag register belongs to channel n, and output `irq_o[n]` always equals that flag bit.
- R2: Register addresses are 0 = flags, 1 = trigger mode, 2 = polarity, 3 = unused (reads zero). Read data appears on `rd_data_o` on the clock edge that samples `rd_en_i`, so it is visible one cycle after the strobe. A write to the mode or polarity register stores bits 3:0.
- R3: An input change reaches the detector through two synchronizer flops. After an input enters its triggering state, its flag is set on the third rising clock edge.
- R4: With the mode bit at 1 (edge), a polarity of 1 triggers on a 0-to-1 transition and a polarity of 0 triggers on a 1-to-0 transition. The flag stays set after the input returns to its previous value.
- R5: With the mode bit at 0 (level), the flag is set on every clock while the synchronized input equals the polarity bit. A clear write made while that level persists leaves the flag set. After the level is gone, a clear write takes effect.
- R6: Writing to the flag register clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R7: When a hardware trigger and a software clear reach the same flag on the same edge, the flag ends up set.
- R8: Bits 31:4 of every register read as zero, and writes to those bits have no effect.
- R9: During reset, the flags, the modes, the polarities, the synchronizers and the read data are all zero, so `irq_o` is 0. Zero mode and polarity select active-low level triggering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in_i | input | 4 | Asynchronous external interrupt inputs |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 4 | Per-channel interrupt request (equals flag) |

## Verification
A flag rises on the third clock edge after its input change: two synchronizer edges, then the flag edge. A write or clear takes effect on the edge that samples the strobe. Read data is due on the edge that samples `rd_en_i`. The bench drives every input on the falling clock edge and runs a cycle-accurate reference model on the rising edge. It compares `irq_o` and any pending read data on the next falling edge. The directed checks count exactly two edges, where the flag must still be clear, and then a third, where it must be set.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  // register addresses (layout chosen for this block)
  localparam int unsigned REG_FLAG = 0;
  localparam int unsigned REG_MODE = 1;
  localparam int unsigned REG_POL  = 2;

  // trigger decision for one channel: md=1 edge, md=0 level; pl=1 rising/high
  function automatic logic trig_hit(input logic md, input logic pl,
                                    input logic cur, input logic prv);
    logic res;
    if (md) res = pl ? (cur & ~prv) : (~cur & prv);
    else    res = (cur == pl);
    return res;
  endfunction

  // next flag value: set beats clear
  function automatic logic flag_next(input logic cur_flag, input logic clr,
                                     input logic set);
    return set | (cur_flag & ~clr);
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= '0;
          else        stg_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] hit_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_i;
  end

  generate
    for (genvar c = 0; c < WIDTH; c++) begin : g_ch
      assign hit_o[c] = trig_hit(mode_i[c], pol_i[c], cur_i[c], prev_q[c]);

      // R4
      edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[c] && hit_o[c]) |-> (cur_i[c] != prev_q[c] && cur_i[c] == pol_i[c]));
      // R5
      level_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i[c] && hit_o[c]) |-> (cur_i[c] == pol_i[c]));
    end
  endgenerate
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [WIDTH-1:0]  hit_i,
  output logic [WIDTH-1:0]  mode_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  flag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [WIDTH-1:0]  mode_q, pol_q, flag_q;
  logic [WIDTH-1:0]  clr_w;
  logic              wr_flag_w, wr_mode_w, wr_pol_w;
  logic [DATA_W-1:0] rd_mux_w;

  assign wr_flag_w = wr_en_i && (addr_i == ADDR_W'(REG_FLAG));
  assign wr_mode_w = wr_en_i && (addr_i == ADDR_W'(REG_MODE));
  assign wr_pol_w  = wr_en_i && (addr_i == ADDR_W'(REG_POL));
  assign clr_w     = wr_flag_w ? wr_data_i[WIDTH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
    end else begin
      if (wr_mode_w) mode_q <= wr_data_i[WIDTH-1:0];
      if (wr_pol_w)  pol_q  <= wr_data_i[WIDTH-1:0];
    end
  end

  generate
    for (genvar c = 0; c < WIDTH; c++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[c] <= 1'b0;
        else        flag_q[c] <= flag_next(flag_q[c], clr_w[c], hit_i[c]);
      end

      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i[c] |=> flag_q[c]);
      // R6
      clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w[c] && !hit_i[c]) |=> !flag_q[c]);
      // R4
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[c] && !clr_w[c]) |=> flag_q[c]);
    end
  endgenerate

  always_comb begin
    rd_mux_w = '0;
    if (addr_i == ADDR_W'(REG_FLAG))      rd_mux_w = DATA_W'(flag_q);
    else if (addr_i == ADDR_W'(REG_MODE)) rd_mux_w = DATA_W'(mode_q);
    else if (addr_i == ADDR_W'(REG_POL))  rd_mux_w = DATA_W'(pol_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux_w;
  end

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode_w |=> mode_q == $past(wr_data_i[WIDTH-1:0]));
  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[DATA_W-1:WIDTH] == '0);

  assign mode_o = mode_q;
  assign pol_o  = pol_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ext_in_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [NUM_CH-1:0] sync_w, hit_w, mode_w, pol_w, flag_w;

  xirq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_in_i), .sync_o(sync_w)
  );

  xirq_detect #(.WIDTH(NUM_CH)) u_detect (
    .clk(clk), .rst_n(rst_n), .cur_i(sync_w), .mode_i(mode_w),
    .pol_i(pol_w), .hit_o(hit_w)
  );

  xirq_regs #(.WIDTH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .hit_i(hit_w),
    .mode_o(mode_w), .pol_o(pol_w), .flag_o(flag_w), .rd_data_o(rd_data_o)
  );

  assign irq_o = flag_w;

  // R9
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (irq_o == '0 && rd_data_o == '0));
endmodule

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  ext_in = 4'hF;
  logic        wr_en = 0, rd_en = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [3:0]  irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_in_i(ext_in), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  // reference model state
  logic [3:0]  m_s1, m_s2, m_prv, m_flag, m_mode, m_pol;
  logic [31:0] m_rd;
  bit          m_rd_pend;

  function automatic logic [3:0] model_hit(logic [3:0] md, logic [3:0] pl,
                                           logic [3:0] cur, logic [3:0] prv);
    logic [3:0] lvl, edg;
    lvl = ~(cur ^ pl);
    edg = (cur ^ prv) & ~(cur ^ pl);
    return (md & edg) | (~md & lvl);
  endfunction

  function automatic logic [31:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return {28'd0, m_flag};
      2'd1: return {28'd0, m_mode};
      2'd2: return {28'd0, m_pol};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prv = 0; m_flag = 0; m_mode = 0; m_pol = 0;
      m_rd = 0; m_rd_pend = 0;
    end else begin
      logic [3:0] h, clr;
      m_rd_pend = rd_en;
      if (rd_en) m_rd = model_read(addr);
      h   = model_hit(m_mode, m_pol, m_s2, m_prv);
      clr = (wr_en && addr == 2'd0) ? wr_data[3:0] : 4'h0;
      m_flag = (m_flag & ~clr) | h;
      if (wr_en && addr == 2'd1) m_mode = wr_data[3:0];
      if (wr_en && addr == 2'd2) m_pol  = wr_data[3:0];
      m_prv = m_s2; m_s2 = m_s1; m_s1 = ext_in;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  bit auto_en = 0;
  always @(negedge clk) begin
    if (rst_n && auto_en) begin
      chk(irq == m_flag, "R1 irq vs model", {28'd0, irq}, {28'd0, m_flag});
      if (m_rd_pend) chk(rd_data == m_rd, "R2 read vs model", rd_data, m_rd);
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", 200000);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(irq == 4'h0, "R9 irq in reset", {28'd0, irq}, 0);
    chk(rd_data == 0, "R9 rdata in reset", rd_data, 0);
    rst_n = 1;
    auto_en = 1;
    wait_cyc(4);
    // R9: zero config is active-low level, reset sync looked low
    chk(irq == 4'hF, "R9 active-low level after reset", {28'd0, irq}, 32'hF);
    wr(2'd0, 32'hF);
    chk(irq == 4'h0, "R6 clear all", {28'd0, irq}, 0);

    // R3 latency of a level trigger on channel 1
    @(negedge clk); ext_in[1] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(irq[1] == 0, "R3 not yet after two edges", {31'd0, irq[1]}, 0);
    @(posedge clk); @(negedge clk);
    chk(irq[1] == 1, "R3 set on third edge", {31'd0, irq[1]}, 1);

    // R5 clear while level persists
    wr(2'd0, 32'h2);
    chk(irq[1] == 1, "R5 clear ineffective while active", {31'd0, irq[1]}, 1);
    ext_in[1] = 1; wait_cyc(3);
    wr(2'd0, 32'h2);
    chk(irq[1] == 0, "R5 clear after level gone", {31'd0, irq[1]}, 0);

    // R6 writing zero keeps flag
    ext_in[2] = 0; wait_cyc(4); ext_in[2] = 1; wait_cyc(3);
    wr(2'd0, 32'h0);
    chk(irq[2] == 1, "R6 zero write keeps flag", {31'd0, irq[2]}, 1);
    wr(2'd0, 32'h4);
    chk(irq[2] == 0, "R6 one write clears", {31'd0, irq[2]}, 0);

    // R2 / R8 register access
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v);
    chk(v == 32'hF, "R8 mode upper bits ignored", v, 32'hF);
    wr(2'd2, 32'hA5A5_A5A5);
    rd(2'd2, v);
    chk(v == 32'h5, "R2 polarity readback", v, 32'h5);
    rd(2'd3, v);
    chk(v == 32'h0, "R2 unused address reads zero", v, 0);
    wr(2'd0, 32'hF);
    rd(2'd0, v);
    chk(v == 32'h0, "R8 flag reg clear and reserved zero", v, 0);

    // R4 edge mode: ch0 rising, ch1 falling
    ext_in[0] = 0; wait_cyc(4);
    chk(irq[0] == 0, "R4 falling ignored on rising channel", {31'd0, irq[0]}, 0);
    ext_in[0] = 1; wait_cyc(3);
    chk(irq[0] == 1, "R4 rising edge sets", {31'd0, irq[0]}, 1);
    ext_in[0] = 0; wait_cyc(4);
    chk(irq[0] == 1, "R4 flag sticky after return", {31'd0, irq[0]}, 1);
    ext_in[1] = 0; wait_cyc(3);
    chk(irq[1] == 1, "R4 falling edge sets", {31'd0, irq[1]}, 1);

    // R7 set beats clear on the same edge (ch2 rising)
    ext_in[2] = 0; wait_cyc(4);
    wr(2'd0, 32'hF);
    ext_in[2] = 1;
    repeat (2) @(posedge clk);
    wr(2'd0, 32'h4);
    chk(irq[2] == 1, "R7 set wins over clear", {31'd0, irq[2]}, 1);
    wr(2'd0, 32'h4);
    chk(irq[2] == 0, "R7 later clear works", {31'd0, irq[2]}, 0);

    // random phase, fixed seed
    void'($urandom(32'h1BADC0DE));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) ext_in = ext_in ^ 4'($urandom());
      wr_en = ($urandom_range(5) == 0);
      rd_en = ($urandom_range(3) == 0);
      addr  = 2'($urandom());
      wr_data = $urandom();
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    wait_cyc(4);
    finish_run();
  end
endmodule